// File: doc/BRIEF.md
# Multi-Width Serial Flash Command Sequencer

This block is the master side of a serial memory link. One command is presented on its input pins and accepted with a one-cycle `start` pulse. The block then drives chip select, the serial clock and up to eight bidirectional data lanes through one frame. A frame has up to five phases: opcode, address, mode bits, idle dummy beats, and data. Each phase can be left out, and each one picks its own lane count of 1, 2, 4 or 8. Write data is pulled one byte at a time from a byte source. Read data leaves as one-cycle byte strobes. A one-cycle `done` pulse closes every frame.

The serial clock runs at the system clock divided by an even number, `2*half_div`. A two-bit mode input selects the idle level and the sampling edge, as in the four common SPI modes. A plain read is set up as follows: opcode 0x03 on one lane, a 24-bit address on one lane, no mode bits, no dummy beats, and a one-lane read.

Top module: `flash_cmd_seq`

## Requirements
- R1: Enabled phases go out in the fixed order opcode, address, mode bits, dummy, data. Within a phase of N lanes, one beat carries N bits, most significant first. Lane N-1 carries the highest bit of each group. Lanes N and above are driven 0 with output enable low. The data lines do not change during a beat.
- R2: A disabled opcode, address or mode phase takes no beats. A zero dummy count and a zero byte count likewise add no beats. A frame with nothing enabled consists of the lead and tail periods only.
- R3: The address size code and the mode size code each select 8*(code+1) bits: code 0 is 8, 1 is 16, 2 is 24 and 3 is 32. Only the low bits of that length of the 32-bit value are sent.
- R4: The dummy phase lasts exactly `cmd_dummy` beats, from 0 to 255. All output enables are low throughout it.
- R5: A write frame sends `cmd_dat_bytes` bytes. For each byte, `tx_take` pulses once, and `tx_byte` is consumed in that same cycle.
- R6: A read frame releases all output enables. It returns `cmd_dat_bytes` bytes, each marked by a one-cycle `rx_valid`. With one lane, lane 1 is sampled. With N>1 lanes, lanes N-1..0 are sampled, with the higher lane holding the more significant bit.
- R7: One beat lasts `2*half_div` system clocks, with 0 treated as 1. Outside the phases, `sck` rests at `spi_mode[1]`. The sampling edge is the one where `sck` moves to the inverse of `spi_mode[1]^spi_mode[0]`.
- R8: `cs_n` falls on the clock after `start`. The first beat begins `half_div` clocks later. `cs_n` rises `2*half_div` clocks after the last beat ends, so it stays low for `half_div*(3+2*beats)` clocks. `done` is high for exactly the first cycle in which `cs_n` is high again. While idle, `cs_n` is high and all enables are low.
- R9: `start` is ignored while a frame is in progress. It does not change that frame and does not begin another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the command on the cmd pins |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cmd_op_en | input | 1 | Opcode phase present |
| cmd_op | input | 8 | Opcode byte |
| cmd_op_lanes | input | 4 | Opcode lane count (1,2,4,8) |
| cmd_adr_en | input | 1 | Address phase present |
| cmd_adr | input | 32 | Address value |
| cmd_adr_size | input | 2 | Address length code |
| cmd_adr_lanes | input | 4 | Address lane count |
| cmd_mb_en | input | 1 | Mode-bits phase present |
| cmd_mb | input | 32 | Mode-bits value |
| cmd_mb_size | input | 2 | Mode-bits length code |
| cmd_mb_lanes | input | 4 | Mode-bits lane count |
| cmd_dummy | input | 8 | Dummy beat count |
| cmd_dat_bytes | input | LEN_W | Data byte count, 0 for none |
| cmd_dat_write | input | 1 | 1 = write data, 0 = read data |
| cmd_dat_lanes | input | 4 | Data lane count |
| spi_mode | input | 2 | Clock polarity (bit 1) and phase (bit 0) |
| half_div | input | DIV_W | System clocks per half beat |
| tx_byte | input | 8 | Byte to send, consumed when tx_take is high |
| tx_take | output | 1 | Write byte consumed this cycle |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | rx_byte valid this cycle |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 8 | Lane output values |
| io_oe | output | 8 | Lane output enables |
| io_in | input | 8 | Lane input values |

## Verification
The hardest case to reach is a read where the sampled lane, the beat timing and the mode-dependent sampling edge must all agree. This has to hold after a variable run of opcode, address, mode and dummy beats, at every lane width and in every clock mode. The bench models the memory as a responder that watches `sck`. It changes its lane values right after each sampling edge, to a value computed from the beat index. The expected read bytes then follow arithmetically from where the data phase starts. Sweeps over all four modes, all lane widths per phase, both directions and two or three divisors drive the engine through every phase-to-phase handover. Extra `start` pulses in mid-frame check that they are ignored.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             cmd_op_en,
  input  logic [7:0]       cmd_op,
  input  logic [3:0]       cmd_op_lanes,
  input  logic             cmd_adr_en,
  input  logic [31:0]      cmd_adr,
  input  logic [1:0]       cmd_adr_size,
  input  logic [3:0]       cmd_adr_lanes,
  input  logic             cmd_mb_en,
  input  logic [31:0]      cmd_mb,
  input  logic [1:0]       cmd_mb_size,
  input  logic [3:0]       cmd_mb_lanes,
  input  logic [7:0]       cmd_dummy,
  input  logic [LEN_W-1:0] cmd_dat_bytes,
  input  logic             cmd_dat_write,
  input  logic [3:0]       cmd_dat_lanes,
  input  logic [1:0]       spi_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic [7:0]       tx_byte,
  output logic             tx_take,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             cs_n,
  output logic             sck,
  output logic [7:0]       io_out,
  output logic [7:0]       io_oe,
  input  logic [7:0]       io_in
);
  localparam logic [2:0] P_IDLE = 3'd0, P_LEAD = 3'd1, P_OP = 3'd2, P_ADR = 3'd3,
                         P_MB = 3'd4, P_DUM = 3'd5, P_DAT = 3'd6, P_TAIL = 3'd7;

  logic [2:0]       ph, tgt;
  logic [DIV_W-1:0] hcnt, hlim;
  logic             half, cpol, cpha;
  logic [31:0]      sh;
  logic [7:0]       left, rxs, samp;
  logic [3:0]       ln;
  logic [LEN_W-1:0] nbytes;

  logic             op_en_l, adr_en_l, mb_en_l, wr_l;
  logic [7:0]       op_l, dum_l;
  logic [31:0]      adr_l, mb_l;
  logic [1:0]       adr_sz_l, mb_sz_l;
  logic [3:0]       op_ln_l, adr_ln_l, mb_ln_l, dln_l;
  logic [LEN_W-1:0] dlen_l;

  wire actv  = (ph >= P_OP) && (ph <= P_DAT);
  wire tick  = (hcnt == hlim);
  wire last  = (left == {4'b0, ln});
  wire adv   = (ph == P_LEAD && tick) || (actv && tick && half && last);
  wire rxph  = (ph == P_DAT) && !wr_l;
  wire drive = (ph == P_OP) || (ph == P_ADR) || (ph == P_MB) || (ph == P_DAT && wr_l);

  assign busy    = (ph != P_IDLE);
  assign sck     = cpol ^ (actv & (cpha ^ half));
  assign tx_take = adv && (tgt == P_DAT) && wr_l;

  always_comb begin
    tgt = P_TAIL;
    if (ph < P_DAT && dlen_l != '0) tgt = P_DAT;
    if (ph < P_DUM && dum_l != 8'd0) tgt = P_DUM;
    if (ph < P_MB && mb_en_l)        tgt = P_MB;
    if (ph < P_ADR && adr_en_l)      tgt = P_ADR;
    if (ph < P_OP && op_en_l)        tgt = P_OP;
    if (ph == P_DAT && nbytes != '0) tgt = P_DAT;
  end

  always_comb begin
    int idx;
    io_out = 8'd0;
    io_oe  = 8'd0;
    samp   = 8'd0;
    for (int k = 0; k < 8; k++) begin
      idx = 32 - int'(ln) + k;
      if (k < int'(ln) && actv) begin
        io_out[k] = sh[idx[4:0]];
        io_oe[k]  = drive;
        samp[k]   = io_in[k];
      end
    end
    if (ln == 4'd1) samp = {7'd0, io_in[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; hcnt <= '0; hlim <= '0; half <= 1'b0; cpol <= 1'b0; cpha <= 1'b0;
      sh <= '0; left <= '0; ln <= 4'd1; nbytes <= '0; rxs <= '0;
      cs_n <= 1'b1; done <= 1'b0; rx_valid <= 1'b0; rx_byte <= '0;
      op_en_l <= 1'b0; adr_en_l <= 1'b0; mb_en_l <= 1'b0; wr_l <= 1'b0;
      op_l <= '0; dum_l <= '0; adr_l <= '0; mb_l <= '0; adr_sz_l <= '0; mb_sz_l <= '0;
      op_ln_l <= 4'd1; adr_ln_l <= 4'd1; mb_ln_l <= 4'd1; dln_l <= 4'd1; dlen_l <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      if (ph == P_IDLE) begin
        cpol <= spi_mode[1];
        if (start) begin
          cpha <= spi_mode[0];
          hlim <= (half_div == '0) ? '0 : half_div - 1'b1;
          op_en_l <= cmd_op_en;   op_l <= cmd_op;         op_ln_l <= cmd_op_lanes;
          adr_en_l <= cmd_adr_en; adr_l <= cmd_adr;       adr_sz_l <= cmd_adr_size;
          adr_ln_l <= cmd_adr_lanes;
          mb_en_l <= cmd_mb_en;   mb_l <= cmd_mb;         mb_sz_l <= cmd_mb_size;
          mb_ln_l <= cmd_mb_lanes;
          dum_l <= cmd_dummy;     dlen_l <= cmd_dat_bytes; wr_l <= cmd_dat_write;
          dln_l <= cmd_dat_lanes;
          cs_n <= 1'b0; ph <= P_LEAD; hcnt <= '0; half <= 1'b0;
        end
      end else begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) half <= ~half;
        if (rxph && tick && !half) rxs <= (rxs << ln) | samp;
        if (actv && tick && half) begin
          sh   <= sh << ln;
          left <= left - {4'b0, ln};
        end
        if (rxph && adv) begin
          rx_valid <= 1'b1;
          rx_byte  <= rxs;
        end
        if (adv) begin
          half <= 1'b0;
          ph   <= tgt;
          case (tgt)
            P_OP:  begin sh <= {op_l, 24'd0}; left <= 8'd8; ln <= op_ln_l; end
            P_ADR: begin
              sh <= adr_l << {2'(2'd3 - adr_sz_l), 3'b000};
              left <= (8'(adr_sz_l) + 8'd1) << 3; ln <= adr_ln_l;
            end
            P_MB:  begin
              sh <= mb_l << {2'(2'd3 - mb_sz_l), 3'b000};
              left <= (8'(mb_sz_l) + 8'd1) << 3; ln <= mb_ln_l;
            end
            P_DUM: begin sh <= '0; left <= dum_l; ln <= 4'd1; end
            P_DAT: begin
              sh <= wr_l ? {tx_byte, 24'd0} : 32'd0;
              left <= 8'd8; ln <= dln_l;
              nbytes <= (ph == P_DAT) ? nbytes - 1'b1 : dlen_l - 1'b1;
            end
            default: begin sh <= '0; ln <= 4'd1; end
          endcase
        end
        if (ph == P_TAIL && tick && half) begin
          ph <= P_IDLE; cs_n <= 1'b1; done <= 1'b1;
        end
      end
    end
  end

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && io_oe == 8'd0));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_dummy_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_DUM) |-> (io_oe == 8'd0));
  assert_rx_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxph |-> (io_oe == 8'd0));
  assert_take_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (!cs_n && wr_l));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && ph != P_TAIL) |=> !cs_n);
  assert_tail_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_TAIL && $past(ph) == P_TAIL) |-> $stable(sck));
  assert_beat_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (actv && half) |-> ($stable(io_out) && $stable(io_oe)));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, tx_take, rx_valid, cs_n, sck;
  logic [7:0] rx_byte, io_out, io_oe, io_in, tx_byte;
  logic cmd_op_en = 0, cmd_adr_en = 0, cmd_mb_en = 0, cmd_dat_write = 0;
  logic [7:0] cmd_op = 0, cmd_dummy = 0;
  logic [3:0] cmd_op_lanes = 1, cmd_adr_lanes = 1, cmd_mb_lanes = 1, cmd_dat_lanes = 1;
  logic [31:0] cmd_adr = 0, cmd_mb = 0;
  logic [1:0] cmd_adr_size = 0, cmd_mb_size = 0, spi_mode = 2'd2;
  logic [15:0] cmd_dat_bytes = 0;
  logic [7:0] half_div = 8'd1;

  int total = 0, bad = 0, seed = 0, rcnt = 0, tx_idx = 0;
  logic cs_prev = 1'b1;
  logic [7:0] rec_o [512];
  logic [7:0] rec_e [512];
  logic [7:0] eo [512];
  logic [7:0] eoe [512];
  logic [7:0] rxg [64];
  int eb, d0, d1;
  int lanes_tab [4] = '{1, 2, 4, 8};

  always #4 clk = ~clk;

  flash_cmd_seq dut (.*);

  function automatic logic [7:0] pat(int b, int s);
    return 8'(b * 29 + s * 7 + 3);
  endfunction
  function automatic logic [7:0] txb(int j, int s);
    return 8'(j * 53 + s * 11 + 90);
  endfunction

  assign io_in   = pat(rcnt, seed);
  assign tx_byte = txb(tx_idx, seed);

  always @(posedge clk)
    if (start && !busy) tx_idx <= 0;
    else if (tx_take) tx_idx <= tx_idx + 1;

  // memory-side responder: records each beat at the sampling edge, then moves on
  always @(sck or cs_n) begin
    if (cs_n !== cs_prev) begin
      if (!cs_n) rcnt = 0;
      cs_prev = cs_n;
    end else if (!cs_n && sck === ~(spi_mode[1] ^ spi_mode[0])) begin
      if (rcnt < 512) begin rec_o[rcnt] = io_out; rec_e[rcnt] = io_oe; end
      rcnt = rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s seed=%0d actual=%0d expected=%0d", req, seed, act, exp);
    end
  endtask

  task automatic addf(input logic [31:0] v, input int bits, input int n, input bit oe);
    for (int i = 0; i < bits / n; i++) begin
      logic [7:0] o;
      o = 8'd0;
      for (int k = 0; k < n; k++) o[k] = v[bits - 1 - i * n - (n - 1 - k)];
      eo[eb] = o;
      eoe[eb] = oe ? 8'((1 << n) - 1) : 8'd0;
      eb++;
    end
  endtask

  task automatic build();
    eb = 0;
    if (cmd_op_en) addf({24'd0, cmd_op}, 8, int'(cmd_op_lanes), 1'b1);
    if (cmd_adr_en) addf(cmd_adr, 8 * (int'(cmd_adr_size) + 1), int'(cmd_adr_lanes), 1'b1);
    if (cmd_mb_en) addf(cmd_mb, 8 * (int'(cmd_mb_size) + 1), int'(cmd_mb_lanes), 1'b1);
    d0 = eb;
    for (int i = 0; i < int'(cmd_dummy); i++) begin eo[eb] = 0; eoe[eb] = 0; eb++; end
    d1 = eb;
    for (int j = 0; j < int'(cmd_dat_bytes); j++)
      if (cmd_dat_write) addf({24'd0, txb(j, seed)}, 8, int'(cmd_dat_lanes), 1'b1);
      else addf(32'd0, 8, int'(cmd_dat_lanes), 1'b0);
  endtask

  task automatic frame(input bit restart);
    int h, exp_cs, csl, dn, rxn, cyc, post, mism, dz;
    bit done_ok, rs;
    build();
    h = (half_div == 0) ? 1 : int'(half_div);
    exp_cs = h * (3 + 2 * eb);
    rs = restart && exp_cs > 12;
    csl = 0; dn = 0; rxn = 0; cyc = 0; post = 0; done_ok = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (cyc < 30000 && post < 3) begin
      if (!cs_n) csl++;
      if (rx_valid && rxn < 64) begin rxg[rxn] = rx_byte; rxn++; end
      if (done) begin dn++; if (!cs_n) done_ok = 0; end
      if (dn > 0) post++;
      start = (rs && cyc == 4);
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(rcnt == eb, "R2 beat count", rcnt, eb);
    mism = -1;
    for (int i = 0; i < eb && i < 512 && i < rcnt; i++)
      if (mism < 0 && (rec_o[i] !== eo[i] || rec_e[i] !== eoe[i])) mism = i;
    if (mism >= 0)
      chk(0, "R1 lane stream", int'({rec_e[mism], rec_o[mism]}), int'({eoe[mism], eo[mism]}));
    else chk(1, "R1 lane stream", 0, 0);
    if (cmd_dummy != 0) begin
      dz = 0;
      for (int i = d0; i < d1 && i < rcnt && i < 512; i++) dz = dz | int'(rec_e[i]);
      chk(dz == 0, "R4 dummy enables", dz, 0);
    end
    chk(csl == exp_cs, "R7 R8 select length", csl, exp_cs);
    chk(dn == 1 && done_ok, "R8 done pulse", dn, 1);
    chk(sck == spi_mode[1], "R7 idle clock", int'(sck), int'(spi_mode[1]));
    if (rs) chk(dn == 1 && csl == exp_cs, "R9 start ignored", csl, exp_cs);
    if (cmd_dat_bytes != 0 && cmd_dat_write)
      chk(tx_idx == int'(cmd_dat_bytes), "R5 bytes taken", tx_idx, int'(cmd_dat_bytes));
    if (cmd_dat_bytes != 0 && !cmd_dat_write) begin
      int n, bpb;
      n = int'(cmd_dat_lanes); bpb = 8 / n;
      chk(rxn == int'(cmd_dat_bytes), "R6 byte count", rxn, int'(cmd_dat_bytes));
      for (int j = 0; j < int'(cmd_dat_bytes) && j < rxn; j++) begin
        logic [7:0] v, p;
        v = 8'd0;
        for (int i = 0; i < bpb; i++) begin
          p = pat(d1 + j * bpb + i, seed);
          v = (n == 1) ? {v[6:0], p[1]} : 8'((v << n) | (p & 8'((1 << n) - 1)));
        end
        chk(rxg[j] == v, "R6 read byte", int'(rxg[j]), int'(v));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R8 reset idle", int'({busy, cs_n}), 1);
    chk(io_oe == 8'd0, "R8 reset enables", int'(io_oe), 0);
    chk(sck == 1'b1, "R7 reset clock level", int'(sck), 1);

    // R3 plain read: 0x03, 24-bit address, one lane each, read on lane 1
    seed = 1; spi_mode = 2'd0; half_div = 8'd2;
    cmd_op_en = 1; cmd_op = 8'h03; cmd_op_lanes = 1;
    cmd_adr_en = 1; cmd_adr = 32'hA5123456; cmd_adr_size = 2'd2; cmd_adr_lanes = 1;
    cmd_mb_en = 0; cmd_dummy = 0; cmd_dat_bytes = 3; cmd_dat_write = 0; cmd_dat_lanes = 1;
    frame(1'b0);
    chk(eb == 8 + 24 + 24, "R3 plain read beats", eb, 56);

    // R2 instruction only, then an empty frame
    seed = 2; cmd_adr_en = 0; cmd_dat_bytes = 0; cmd_op = 8'h06; spi_mode = 2'd3;
    frame(1'b0);
    seed = 3; cmd_op_en = 0; half_div = 8'd0;
    frame(1'b0);

    // R4 longest dummy run followed by a quad read
    seed = 4; cmd_dummy = 8'd255; cmd_dat_bytes = 2; cmd_dat_lanes = 4; half_div = 8'd1;
    frame(1'b1);

    idx = 0;
    for (int m = 0; m < 4; m++)
      for (int di = 0; di < 4; di++)
        for (int w = 0; w < 2; w++)
          for (int h = 1; h < 3; h++) begin
            idx++; seed = 10 + idx;
            spi_mode = 2'(m); half_div = 8'(h);
            cmd_op_en = 1; cmd_op = 8'(idx * 13 + 7); cmd_op_lanes = 1;
            cmd_adr_en = 1; cmd_adr = 32'(idx * 32'h9E3779B1);
            cmd_adr_size = 2'(idx % 4); cmd_adr_lanes = 4'(lanes_tab[idx % 4]);
            cmd_mb_en = (idx % 3 == 0); cmd_mb = 32'(idx * 32'h85EBCA6B);
            cmd_mb_size = 2'((idx / 4) % 4); cmd_mb_lanes = 4'(lanes_tab[(idx / 2) % 4]);
            cmd_dummy = 8'(idx % 5); cmd_dat_bytes = 16'(1 + idx % 3);
            cmd_dat_write = w[0]; cmd_dat_lanes = 4'(lanes_tab[di]);
            frame(idx % 7 == 3);
          end

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          idx++; seed = 10 + idx;
          spi_mode = 2'(idx % 4); half_div = 8'(1 + idx % 3);
          cmd_op_en = (idx % 5 != 1); cmd_op = 8'(idx * 5 + 1); cmd_op_lanes = 4'(lanes_tab[a]);
          cmd_adr_en = (idx % 5 != 2); cmd_adr = 32'(idx * 32'hC2B2AE35);
          cmd_adr_size = 2'(idx % 4); cmd_adr_lanes = 4'(lanes_tab[b]);
          cmd_mb_en = (idx % 5 != 3); cmd_mb = 32'(idx * 32'h27D4EB2F);
          cmd_mb_size = 2'((idx / 3) % 4); cmd_mb_lanes = 4'(lanes_tab[c]);
          cmd_dummy = (idx % 4 == 0) ? 8'd0 : 8'(idx % 9);
          cmd_dat_bytes = 16'(idx % 3); cmd_dat_write = idx[0];
          cmd_dat_lanes = 4'(lanes_tab[(a + c) % 4]);
          frame(idx % 4 == 1);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule